// File: doc/BRIEF.md
# Host/Coprocessor Command Mailbox

This block sits between a host CPU and a sound coprocessor CPU and carries bytes in both directions. The host sees two I/O addresses. One accepts a command byte and reads back a status byte. The other accepts a data byte and reads back the coprocessor's reply byte. The coprocessor sees a small port space decoded from its low address bits. Through it the coprocessor fetches the command and data bytes, posts its reply and reads the same status byte.

Two sticky flags coordinate the two sides. The command flag rises when the host issues a command and drops when the coprocessor acknowledges it. The data flag tracks which side owns the data channel. The coprocessor can also force each flag from a stored bit: the low bit of its page register, or one bit of a volume register. All accesses are single-cycle strobes, sampled on the rising clock edge. Read data is combinational and reflects the state before that edge.

Top module: `snd_mailbox`

## Requirements
- R1: A synchronous reset clears the command, data and reply registers and both flags. The host then reads status 0x7E and reply 0x00, and coprocessor ports 1 and 2 read 0x00.
- R2: A host write with `host_sel`=1 stores the byte as the command and sets the command flag.
- R3: A host write with `host_sel`=0 stores the byte as the data byte and sets the data flag.
- R4: A host read with `host_sel`=1 returns the status byte: bit 7 is the data flag, bits 6 to 1 are ones and bit 0 is the command flag. This read changes no state.
- R5: A host read with `host_sel`=0 returns the reply register and clears the data flag.
- R6: A coprocessor read of port 1 returns the command byte. A read of port 4 returns the status byte defined in R4.
- R7: A coprocessor read of port 2 returns the data byte and clears the data flag.
- R8: A coprocessor write to port 3 loads the reply register and sets the data flag.
- R9: Any coprocessor read or write of port 5 clears the command flag.
- R10: A coprocessor write to port 0 stores the page register. Any access to port 10 then sets the data flag to the inverse of page bit 0.
- R11: A coprocessor write to port 9 stores the volume register. Any access to port 11 then sets the command flag equal to volume bit 5.
- R12: When both sides act on the same flag in the same cycle, the coprocessor's action decides the flag's next value. The host's register writes still take effect.
- R13: A coprocessor read of any port other than 1, 2 and 4 returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_sel | input | 1 | Host address select: 1 = command/status, 0 = data/reply |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (status or reply) |
| cop_addr | input | 4 | Coprocessor port number |
| cop_wr | input | 1 | Coprocessor write strobe |
| cop_rd | input | 1 | Coprocessor read strobe |
| cop_wdata | input | 8 | Coprocessor write data |
| cop_rdata | output | 8 | Coprocessor read data |

## Verification
The assertions check the flag rules on every cycle. These cover the set-on-command and clear-on-acknowledge behaviour, the clear when the coprocessor reads the data byte, and the forced value from the page bit. They also check that the reply register moves only on a port 3 write, and that the coprocessor wins when both sides drive the data flag. Other behaviours are visible only through the bench's scenarios: the exact byte returned by each read path, the fixed ones in the status byte, the 0xFF on unmapped ports, and whether host status reads are truly free of side effects. The bench sweeps every coprocessor port under both strobes and long mixed sequences from both sides, and compares the result against a flag model.

// File: rtl/snd_mailbox.sv
module snd_mailbox #(
  parameter int DW         = 8,
  parameter int AW         = 4,
  parameter int PAGE_PORT  = 0,
  parameter int CMD_PORT   = 1,
  parameter int DIN_PORT   = 2,
  parameter int DOUT_PORT  = 3,
  parameter int STAT_PORT  = 4,
  parameter int CCLR_PORT  = 5,
  parameter int VOL_PORT   = 9,
  parameter int DSYNC_PORT = 10,
  parameter int CSYNC_PORT = 11,
  parameter int VOL_BIT    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_sel,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic [AW-1:0] cop_addr,
  input  logic          cop_wr,
  input  logic          cop_rd,
  input  logic [DW-1:0] cop_wdata,
  output logic [DW-1:0] cop_rdata
);
  localparam logic [AW-1:0] A_PAGE  = AW'(PAGE_PORT);
  localparam logic [AW-1:0] A_CMD   = AW'(CMD_PORT);
  localparam logic [AW-1:0] A_DIN   = AW'(DIN_PORT);
  localparam logic [AW-1:0] A_DOUT  = AW'(DOUT_PORT);
  localparam logic [AW-1:0] A_STAT  = AW'(STAT_PORT);
  localparam logic [AW-1:0] A_CCLR  = AW'(CCLR_PORT);
  localparam logic [AW-1:0] A_VOL   = AW'(VOL_PORT);
  localparam logic [AW-1:0] A_DSYNC = AW'(DSYNC_PORT);
  localparam logic [AW-1:0] A_CSYNC = AW'(CSYNC_PORT);

  logic [DW-1:0] cmd_q, din_q, dout_q;
  logic          dflag_q, cflag_q, page_b0_q, vol_bit_q;
  logic          dflag_d, cflag_d;
  logic [DW-1:0] status;

  wire cop_acc   = cop_wr | cop_rd;
  wire h_wr_cmd  = host_wr & host_sel;
  wire h_wr_dat  = host_wr & ~host_sel;
  wire h_rd_dat  = host_rd & ~host_sel & ~host_wr;

  assign status     = {dflag_q, {(DW-2){1'b1}}, cflag_q};
  assign host_rdata = host_sel ? status : dout_q;

  always_comb begin
    cop_rdata = '1;
    if (cop_rd) begin
      case (cop_addr)
        A_CMD:   cop_rdata = cmd_q;
        A_DIN:   cop_rdata = din_q;
        A_STAT:  cop_rdata = status;
        default: cop_rdata = '1;
      endcase
    end
  end

  always_comb begin
    dflag_d = dflag_q;
    if (h_wr_dat)      dflag_d = 1'b1;
    else if (h_rd_dat) dflag_d = 1'b0;
    if (cop_rd && cop_addr == A_DIN)         dflag_d = 1'b0;
    else if (cop_wr && cop_addr == A_DOUT)   dflag_d = 1'b1;
    else if (cop_acc && cop_addr == A_DSYNC) dflag_d = ~page_b0_q;
  end

  always_comb begin
    cflag_d = cflag_q;
    if (h_wr_cmd) cflag_d = 1'b1;
    if (cop_acc && cop_addr == A_CCLR)       cflag_d = 1'b0;
    else if (cop_acc && cop_addr == A_CSYNC) cflag_d = vol_bit_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      din_q     <= '0;
      dout_q    <= '0;
      dflag_q   <= 1'b0;
      cflag_q   <= 1'b0;
      page_b0_q <= 1'b0;
      vol_bit_q <= 1'b0;
    end else begin
      dflag_q <= dflag_d;
      cflag_q <= cflag_d;
      if (h_wr_cmd) cmd_q <= host_wdata;
      if (h_wr_dat) din_q <= host_wdata;
      if (cop_wr && cop_addr == A_DOUT) dout_q    <= cop_wdata;
      if (cop_wr && cop_addr == A_PAGE) page_b0_q <= cop_wdata[0];
      if (cop_wr && cop_addr == A_VOL)  vol_bit_q <= cop_wdata[VOL_BIT];
    end
  end

  AST_CMD_SET: assert property (@(posedge clk) disable iff (rst)
    (h_wr_cmd && !(cop_acc && (cop_addr == A_CCLR || cop_addr == A_CSYNC))) |=> cflag_q); // R2
  AST_DATA_CLR: assert property (@(posedge clk) disable iff (rst)
    (cop_rd && cop_addr == A_DIN) |=> !dflag_q); // R7
  AST_REPLY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(cop_wr && cop_addr == A_DOUT) |=> $stable(dout_q)); // R8
  AST_CMD_ACK: assert property (@(posedge clk) disable iff (rst)
    (cop_acc && cop_addr == A_CCLR) |=> !cflag_q); // R9
  AST_PAGE_SYNC: assert property (@(posedge clk) disable iff (rst)
    (cop_acc && cop_addr == A_DSYNC) |=> (dflag_q == !$past(page_b0_q))); // R10
  AST_COP_WINS: assert property (@(posedge clk) disable iff (rst)
    (h_wr_dat && cop_rd && cop_addr == A_DIN) |=> !dflag_q); // R12
endmodule

// File: tb/snd_mailbox_bench.sv
module snd_mailbox_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [3:0] cop_addr = '0;
  logic       cop_wr = 1'b0, cop_rd = 1'b0;
  logic [7:0] cop_wdata = '0;
  logic [7:0] cop_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] m_cmd, m_din, m_dout;
  logic       m_df, m_cf, m_pg, m_vol;

  always #5 clk = ~clk;

  snd_mailbox u_snd_mailbox (
    .clk(clk), .rst(rst),
    .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cop_addr(cop_addr), .cop_wr(cop_wr), .cop_rd(cop_rd),
    .cop_wdata(cop_wdata), .cop_rdata(cop_rdata)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_status();
    return {m_df, 6'b111111, m_cf};
  endfunction

  task automatic cyc(string ctx, bit hw, bit hr, bit hs, logic [7:0] hd,
                     bit cw, bit cr, logic [3:0] ca, logic [7:0] cd);
    logic nd, nc;
    logic [7:0] ecop;
    @(negedge clk);
    host_wr = hw; host_rd = hr; host_sel = hs; host_wdata = hd;
    cop_wr = cw; cop_rd = cr; cop_addr = ca; cop_wdata = cd;
    #1;
    if (hr) begin
      if (hs) chk({ctx, "/R4 host status"}, host_rdata, m_status());
      else    chk({ctx, "/R5 host reply"}, host_rdata, m_dout);
    end
    if (cr) begin
      case (ca)
        4'd1:    ecop = m_cmd;
        4'd2:    ecop = m_din;
        4'd4:    ecop = m_status();
        default: ecop = 8'hFF;
      endcase
      if (ca == 4'd1 || ca == 4'd4) chk({ctx, "/R6 cop read"}, cop_rdata, ecop);
      else if (ca == 4'd2)          chk({ctx, "/R7 cop data"}, cop_rdata, ecop);
      else                          chk({ctx, "/R13 cop unmapped"}, cop_rdata, ecop);
    end
    nd = m_df; nc = m_cf;
    if (hw && !hs) nd = 1'b1;
    else if (hr && !hs) nd = 1'b0;
    if (hw && hs) nc = 1'b1;
    if (cr && ca == 4'd2) nd = 1'b0;
    else if (cw && ca == 4'd3) nd = 1'b1;
    else if ((cw || cr) && ca == 4'd10) nd = ~m_pg;
    if ((cw || cr) && ca == 4'd5) nc = 1'b0;
    else if ((cw || cr) && ca == 4'd11) nc = m_vol;
    @(posedge clk);
    if (hw && hs) m_cmd = hd;
    if (hw && !hs) m_din = hd;
    if (cw && ca == 4'd3) m_dout = cd;
    if (cw && ca == 4'd0) m_pg = cd[0];
    if (cw && ca == 4'd9) m_vol = cd[5];
    m_df = nd; m_cf = nc;
  endtask

  task automatic status_is(string ctx);
    cyc(ctx, 0, 1, 1, 8'h00, 0, 0, 4'd0, 8'h00);
  endtask

  initial begin
    m_cmd = '0; m_din = '0; m_dout = '0;
    m_df = 0; m_cf = 0; m_pg = 0; m_vol = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    cyc("R1", 0, 1, 1, 0, 0, 1, 4'd1, 0);
    cyc("R1", 0, 1, 0, 0, 0, 1, 4'd2, 0);
    chk("R1 model status", m_status(), 8'h7E);

    // R2, R3 host writes, R6/R7 coprocessor fetch
    cyc("R2", 1, 0, 1, 8'hA5, 0, 0, 0, 0);
    status_is("R2");
    cyc("R3", 1, 0, 0, 8'h3C, 0, 1, 4'd1, 0);
    status_is("R3");
    cyc("R7", 0, 0, 0, 0, 0, 1, 4'd2, 0);
    status_is("R7");
    cyc("R4", 0, 0, 0, 0, 0, 1, 4'd4, 0);
    status_is("R4");

    // R8 reply, R5 host read clears
    cyc("R8", 0, 0, 0, 0, 1, 0, 4'd3, 8'h81);
    status_is("R8");
    cyc("R5", 0, 1, 0, 0, 0, 0, 0, 0);
    status_is("R5");

    // R9 port 5 acknowledge, by read and by write
    for (int k = 0; k < 2; k++) begin
      cyc("R9", 1, 0, 1, 8'h10 + 8'(k), 0, 0, 0, 0);
      cyc("R9", 0, 0, 0, 0, k == 0, k == 1, 4'd5, 0);
      status_is("R9");
    end

    // R10, R11 forced flags, all page/volume values and both strobes
    for (int v = 0; v < 2; v++) begin
      for (int k = 0; k < 2; k++) begin
        cyc("R10", 0, 0, 0, 0, 1, 0, 4'd0, 8'(v));
        cyc("R10", 0, 0, 0, 0, k == 0, k == 1, 4'd10, 0);
        status_is("R10");
        cyc("R11", 0, 0, 0, 0, 1, 0, 4'd9, 8'(v << 5));
        cyc("R11", 0, 0, 0, 0, k == 0, k == 1, 4'd11, 0);
        status_is("R11");
      end
    end

    // R12 conflicts
    cyc("R12", 1, 0, 0, 8'h77, 0, 1, 4'd2, 0);
    status_is("R12");
    cyc("R12", 1, 0, 1, 8'h66, 0, 1, 4'd5, 0);
    status_is("R12");
    cyc("R12", 0, 0, 0, 0, 0, 1, 4'd1, 0);
    cyc("R12", 0, 1, 0, 0, 1, 0, 4'd3, 8'h5A);
    status_is("R12");

    // R13 sweep of all ports, read strobe
    for (int a = 0; a < 16; a++) cyc("R13", 0, 0, 0, 0, 0, 1, 4'(a), 0);

    // mixed traffic from both sides
    for (int i = 0; i < 4000; i++) begin
      int hop;
      hop = $urandom_range(0, 4);
      cyc("mix", hop == 1, hop >= 2, $urandom_range(0, 1) == 1, 8'($urandom),
          $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
          4'($urandom_range(0, 15)), 8'($urandom));
    end

    @(negedge clk);
    host_wr = 0; host_rd = 0; cop_wr = 0; cop_rd = 0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule